// File: doc/BRIEF.md
# SDRAM Bank Timing Checker

This block watches the command bus between a memory controller and a DDR2-style DRAM and reports any command that breaks a bank timing rule. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command. It also tracks whether each of the eight banks is open or closed. For every bank it keeps the number of cycles since that bank's last activate and since its last effective precharge. It also keeps the number of cycles since the most recent activate to any bank.

The row-to-column delay, minimum active time, precharge time and activate-to-activate spacing are configuration inputs counted in clocks. The same-bank cycle time is their derived sum (active time plus precharge time). A programmable additive latency lets a read or write be posted before the row-to-column delay has elapsed. Such a command is legal when its issue cycle plus the latency reaches the required delay.

When a command breaks a rule, the checker emits a one-cycle error pulse on the following cycle, carrying a rule code and the bank number. The offending command still updates the bank state, so checking continues on the next cycle.

Top module: `bank_timing_monitor`

## Requirements
- R1: With `cs_n` low, the levels {`ras_n`,`cas_n`,`we_n`} decode as follows: 011 is activate, 101 is read, 100 is write and 010 is precharge. The other patterns (001, 000, 111) are not checked. With `cs_n` high the bus is deselected.
- R2: After reset all banks are closed and all timers are saturated, so `err_valid` and `cfg_err` are 0 and the first activate to any bank is legal.
- R3: A read or write to a closed bank reports code 1.
- R4: A read or write to an open bank issued k cycles after its activate reports code 2 when k plus the effective additive latency is less than `cfg_trcd`. Otherwise it reports nothing.
- R5: A precharge to an open bank issued k cycles after its activate reports code 3 when k < `cfg_tras`. A precharge to a closed bank reports nothing and leaves that bank's timers unchanged.
- R6: An activate to a bank that is already open reports code 4.
- R7: An activate to a closed bank issued k cycles after its precharge reports code 5 when k < `cfg_trp`.
- R8: An activate issued k cycles after the previous activate to the same bank reports code 6 when k < `cfg_tras` + `cfg_trp`.
- R9: An activate issued k cycles after an activate to a different bank reports code 7 when k < `cfg_trrd`.
- R10: When an activate breaks several rules, one code is reported. Priority is code 4, then 5, then 6, then 7.
- R11: Each violation raises `err_valid` for exactly the cycle after the offending command, with `err_code` and `err_bank` set. `err_code` is 0 whenever `err_valid` is low. The offending command still updates the bank state.
- R12: `cfg_err` is 1, one cycle later, whenever `cfg_al` exceeds 4. While it is set, the additive latency used for R4 is 0.
- R13: Deselect cycles and the unchecked command patterns have no effect on bank state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | 3 | Bank addressed by the command |
| cfg_trcd | input | 5 | Activate to read/write delay, clocks |
| cfg_tras | input | 5 | Minimum active time, clocks |
| cfg_trp | input | 5 | Precharge time, clocks |
| cfg_trrd | input | 5 | Activate spacing across banks, clocks |
| cfg_al | input | 3 | Additive latency, valid 0 to 4 |
| err_valid | output | 1 | Violation pulse |
| err_code | output | 3 | Rule broken (1 to 7), 0 when idle |
| err_bank | output | 3 | Bank of the offending command |
| cfg_err | output | 1 | Additive latency out of range |

## Verification
A wrong open flag shows at the ports on the next read, write or activate to that bank: a spurious or missing code 1 or code 4 appears one cycle after that command. A timer that is off by one surfaces only at the exact boundary cycle of its rule. For that reason the bench sweeps every spacing across each threshold, for several configuration values, and checks the code one cycle after each command. A precharge that wrongly reloads a closed bank's timer is caught by an immediate activate to that bank.

// File: rtl/bank_mon_pkg.sv
package bank_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_OTHER = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    VIO_NONE       = 3'd0,
    VIO_COL_CLOSED = 3'd1,
    VIO_RCD        = 3'd2,
    VIO_RAS        = 3'd3,
    VIO_ACT_OPEN   = 3'd4,
    VIO_RP         = 3'd5,
    VIO_RC         = 3'd6,
    VIO_RRD        = 3'd7
  } vio_e;

  localparam int unsigned AL_MAX = 4;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import bank_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b111:  cmd = CMD_NOP;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_mon_pkg::*;
#(
  parameter int unsigned NBANK = 8,
  parameter int unsigned CW    = 6,
  localparam int unsigned BW   = $clog2(NBANK)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cmd_e                       cmd,
  input  logic [BW-1:0]              bank,
  output logic [NBANK-1:0]           open_vec,
  output logic [NBANK-1:0][CW-1:0]   act_age,
  output logic [NBANK-1:0][CW-1:0]   pre_age
);

  localparam logic [CW-1:0] AGE_SAT = {CW{1'b1}};
  localparam logic [CW-1:0] AGE_ONE = CW'(1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          hit;
    logic          open_q, open_d, open_en;
    logic [CW-1:0] act_q, act_d, pre_q, pre_d;
    logic          act_en, pre_en;

    assign hit = (bank == BW'(b));

    always_comb begin
      open_en = 1'b0;
      open_d  = open_q;
      if (hit && cmd == CMD_ACT) begin
        open_en = 1'b1;
        open_d  = 1'b1;
      end else if (hit && cmd == CMD_PRE) begin
        open_en = 1'b1;
        open_d  = 1'b0;
      end

      if (hit && cmd == CMD_ACT) begin
        act_en = 1'b1;
        act_d  = AGE_ONE;
      end else begin
        act_en = (act_q != AGE_SAT);
        act_d  = act_q + AGE_ONE;
      end

      if (hit && cmd == CMD_PRE && open_q) begin
        pre_en = 1'b1;
        pre_d  = AGE_ONE;
      end else begin
        pre_en = (pre_q != AGE_SAT);
        pre_d  = pre_q + AGE_ONE;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        act_q  <= AGE_SAT;
        pre_q  <= AGE_SAT;
      end else begin
        if (open_en) open_q <= open_d;
        if (act_en)  act_q  <= act_d;
        if (pre_en)  pre_q  <= pre_d;
      end
    end

    assign open_vec[b] = open_q;
    assign act_age[b]  = act_q;
    assign pre_age[b]  = pre_q;
  end

endmodule

// File: rtl/act_spacing.sv
module act_spacing
  import bank_mon_pkg::*;
#(
  parameter int unsigned BW = 3,
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic [BW-1:0] bank,
  output logic [CW-1:0] gap,
  output logic [BW-1:0] last_bank
);

  localparam logic [CW-1:0] GAP_SAT = {CW{1'b1}};

  logic [CW-1:0] gap_q, gap_d;
  logic          gap_en;
  logic [BW-1:0] last_q, last_d;
  logic          last_en;

  always_comb begin
    last_en = (cmd == CMD_ACT);
    last_d  = bank;
    if (cmd == CMD_ACT) begin
      gap_en = 1'b1;
      gap_d  = CW'(1);
    end else begin
      gap_en = (gap_q != GAP_SAT);
      gap_d  = gap_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_SAT;
      last_q <= '0;
    end else begin
      if (gap_en)  gap_q  <= gap_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign gap       = gap_q;
  assign last_bank = last_q;

endmodule

// File: rtl/rule_check.sv
module rule_check
  import bank_mon_pkg::*;
#(
  parameter int unsigned TW  = 5,
  parameter int unsigned ALW = 3,
  localparam int unsigned CW = TW + 1,
  localparam int unsigned SW = CW + 1
) (
  input  cmd_e           cmd,
  input  logic           bank_open,
  input  logic [CW-1:0]  act_age,
  input  logic [CW-1:0]  pre_age,
  input  logic [CW-1:0]  gap,
  input  logic           same_as_last,
  input  logic [TW-1:0]  cfg_trcd,
  input  logic [TW-1:0]  cfg_tras,
  input  logic [TW-1:0]  cfg_trp,
  input  logic [TW-1:0]  cfg_trrd,
  input  logic [ALW-1:0] cfg_al,
  output vio_e           vio
);

  localparam logic [ALW-1:0] AL_LIM = ALW'(AL_MAX);

  logic [ALW-1:0] eff_al;
  logic [SW-1:0]  ready_at;
  logic [CW-1:0]  trc;

  assign eff_al   = (cfg_al > AL_LIM) ? '0 : cfg_al;
  assign ready_at = SW'(act_age) + SW'(eff_al);
  assign trc      = CW'(cfg_tras) + CW'(cfg_trp);

  always_comb begin
    vio = VIO_NONE;
    case (cmd)
      CMD_RD, CMD_WR: begin
        if (!bank_open)                   vio = VIO_COL_CLOSED;
        else if (ready_at < SW'(cfg_trcd)) vio = VIO_RCD;
      end
      CMD_PRE: begin
        if (bank_open && act_age < CW'(cfg_tras)) vio = VIO_RAS;
      end
      CMD_ACT: begin
        if (bank_open)                             vio = VIO_ACT_OPEN;
        else if (pre_age < CW'(cfg_trp))           vio = VIO_RP;
        else if (act_age < trc)                    vio = VIO_RC;
        else if (!same_as_last && gap < CW'(cfg_trrd)) vio = VIO_RRD;
      end
      default: vio = VIO_NONE;
    endcase
  end

endmodule

// File: rtl/bank_timing_monitor.sv
module bank_timing_monitor
  import bank_mon_pkg::*;
#(
  parameter int unsigned NBANK = 8,
  parameter int unsigned TW    = 5,
  parameter int unsigned ALW   = 3,
  localparam int unsigned BW   = $clog2(NBANK),
  localparam int unsigned CW   = TW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [BW-1:0]  bank_addr,
  input  logic [TW-1:0]  cfg_trcd,
  input  logic [TW-1:0]  cfg_tras,
  input  logic [TW-1:0]  cfg_trp,
  input  logic [TW-1:0]  cfg_trrd,
  input  logic [ALW-1:0] cfg_al,
  output logic           err_valid,
  output logic [2:0]     err_code,
  output logic [BW-1:0]  err_bank,
  output logic           cfg_err
);

  localparam logic [ALW-1:0] AL_LIM = ALW'(AL_MAX);

  cmd_e                     cmd;
  logic [NBANK-1:0]         open_vec;
  logic [NBANK-1:0][CW-1:0] act_age;
  logic [NBANK-1:0][CW-1:0] pre_age;
  logic [CW-1:0]            gap;
  logic [BW-1:0]            last_bank;
  vio_e                     vio;

  cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  bank_tracker #(.NBANK(NBANK), .CW(CW)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .bank     (bank_addr),
    .open_vec (open_vec),
    .act_age  (act_age),
    .pre_age  (pre_age)
  );

  act_spacing #(.BW(BW), .CW(CW)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .bank      (bank_addr),
    .gap       (gap),
    .last_bank (last_bank)
  );

  rule_check #(.TW(TW), .ALW(ALW)) u_rule (
    .cmd          (cmd),
    .bank_open    (open_vec[bank_addr]),
    .act_age      (act_age[bank_addr]),
    .pre_age      (pre_age[bank_addr]),
    .gap          (gap),
    .same_as_last (last_bank == bank_addr),
    .cfg_trcd     (cfg_trcd),
    .cfg_tras     (cfg_tras),
    .cfg_trp      (cfg_trp),
    .cfg_trrd     (cfg_trrd),
    .cfg_al       (cfg_al),
    .vio          (vio)
  );

  logic          err_valid_d, err_valid_q;
  logic [2:0]    err_code_d, err_code_q;
  logic [BW-1:0] err_bank_d, err_bank_q;
  logic          cfg_err_d, cfg_err_q;

  always_comb begin
    err_valid_d = (vio != VIO_NONE);
    err_code_d  = vio;
    err_bank_d  = err_valid_d ? bank_addr : '0;
    cfg_err_d   = (cfg_al > AL_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid_q <= 1'b0;
      err_code_q  <= 3'd0;
      err_bank_q  <= '0;
      cfg_err_q   <= 1'b0;
    end else begin
      err_valid_q <= err_valid_d;
      err_code_q  <= err_code_d;
      err_bank_q  <= err_bank_d;
      cfg_err_q   <= cfg_err_d;
    end
  end

  assign err_valid = err_valid_q;
  assign err_code  = err_code_q;
  assign err_bank  = err_bank_q;
  assign cfg_err   = cfg_err_q;

endmodule

// File: rtl/bank_mon_chk.sv
module bank_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [2:0] bank_addr,
  input logic [2:0] cfg_al,
  input logic       err_valid,
  input logic [2:0] err_code,
  input logic [2:0] err_bank,
  input logic       cfg_err
);

  logic       seen_q;
  logic       prev_act_q;
  logic [2:0] prev_bank_q;
  logic       act_now;

  assign act_now = !cs_n && !ras_n && cas_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      prev_act_q  <= 1'b0;
      prev_bank_q <= 3'd0;
    end else begin
      seen_q      <= 1'b1;
      prev_act_q  <= act_now;
      prev_bank_q <= bank_addr;
    end
  end

  // R11
  code_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> err_code != 3'd0);

  // R11
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |-> err_code == 3'd0);

  // R12
  al_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> cfg_err == ($past(cfg_al) > 3'd4));

  // R13
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && err_valid) |-> (!$past(cs_n) && $past(bank_addr) == err_bank));

  // R6
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_act_q && act_now && bank_addr == prev_bank_q) |=> (err_valid && err_code == 3'd4));

endmodule

bind bank_timing_monitor bank_mon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .bank_addr (bank_addr),
  .cfg_al    (cfg_al),
  .err_valid (err_valid),
  .err_code  (err_code),
  .err_bank  (err_bank),
  .cfg_err   (cfg_err)
);

// File: tb/tb_bank_timing_monitor.sv
module tb_bank_timing_monitor;

  localparam int K_DES = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                 K_REF = 5, K_MRS = 6, K_NOP = 7;

  logic       clk, rst_n;
  logic       cs_n, ras_n, cas_n, we_n;
  logic [2:0] bank_addr;
  logic [4:0] cfg_trcd, cfg_tras, cfg_trp, cfg_trrd;
  logic [2:0] cfg_al;
  logic       err_valid, cfg_err;
  logic [2:0] err_code, err_bank;

  int nchk, nfail, cyc;

  bank_timing_monitor dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_addr(bank_addr), .cfg_trcd(cfg_trcd),
    .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trrd(cfg_trrd),
    .cfg_al(cfg_al), .err_valid(err_valid), .err_code(err_code),
    .err_bank(err_bank), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: cycles=%0d expected finish before 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic set_pins(input int kind, input int bank);
    bank_addr = 3'(bank);
    case (kind)
      K_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      K_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      K_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      K_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      K_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      K_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      K_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b1011;
    endcase
  endtask

  // drive at a negedge, check one register later at the next negedge
  task automatic issue(input int kind, input int bank, input int exp, input string req);
    set_pins(kind, bank);
    @(posedge clk);
    @(negedge clk);
    nchk++;
    if (err_valid !== (exp != 0) || err_code !== 3'(exp) ||
        (exp != 0 && err_bank !== 3'(bank))) begin
      nfail++;
      $display("FAIL %s: valid=%0b code=%0d bank=%0d expected valid=%0b code=%0d bank=%0d",
               req, err_valid, err_code, err_bank, exp != 0, exp, bank);
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) issue(K_DES, 0, 0, req);
  endtask

  task automatic restart(input int trcd, input int tras, input int trp,
                         input int trrd, input int al);
    set_pins(K_DES, 0);
    cfg_trcd = 5'(trcd); cfg_tras = 5'(tras); cfg_trp = 5'(trp);
    cfg_trrd = 5'(trrd); cfg_al = 3'(al);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_flag(input logic exp, input string req);
    nchk++;
    if (cfg_err !== exp) begin
      nfail++;
      $display("FAIL %s: cfg_err=%0b expected %0b", req, cfg_err, exp);
    end
  endtask

  initial begin
    nchk = 0; nfail = 0; cyc = 0;
    rst_n = 1'b0;
    set_pins(K_DES, 0);
    cfg_trcd = 5'd1; cfg_tras = 5'd1; cfg_trp = 5'd1; cfg_trrd = 5'd1; cfg_al = 3'd0;
    @(negedge clk);

    // R2: reset state and first activates legal
    restart(1, 1, 1, 1, 0);
    nchk++;
    if (err_valid !== 1'b0 || err_code !== 3'd0) begin
      nfail++;
      $display("FAIL R2: valid=%0b code=%0d expected 0 0", err_valid, err_code);
    end
    check_flag(1'b0, "R2");
    restart(1, 1, 1, 6, 0);
    for (int b = 0; b < 8; b++) begin
      issue(K_ACT, b, 0, "R2");
      restart(1, 1, 1, 6, 0);
    end

    // R1 / R13: every pattern against a closed bank
    restart(2, 1, 3, 1, 0);
    issue(K_REF, 2, 0, "R13");
    issue(K_MRS, 2, 0, "R13");
    issue(K_NOP, 2, 0, "R13");
    issue(K_RD, 2, 1, "R1 R3");
    issue(K_WR, 2, 1, "R1 R3");
    issue(K_PRE, 2, 0, "R1 R5");
    issue(K_ACT, 2, 0, "R1");
    issue(K_ACT, 2, 4, "R1 R6");
    // deselected activate pattern does nothing
    restart(1, 1, 1, 1, 0);
    {cs_n, ras_n, cas_n, we_n} = 4'b1011; bank_addr = 3'd4;
    @(posedge clk); @(negedge clk);
    issue(K_RD, 4, 1, "R13");
    // refresh pattern does not open a bank
    issue(K_REF, 6, 0, "R13");
    issue(K_WR, 6, 1, "R13");

    // R4: activate-to-column sweep with additive latency
    for (int trcd = 1; trcd <= 6; trcd++)
      for (int al = 0; al <= 4; al++)
        for (int k = 1; k <= 7; k++) begin
          restart(trcd, 1, 1, 1, al);
          issue(K_ACT, k % 8, 0, "R4");
          idle(k - 1, "R4");
          issue((k % 2) ? K_RD : K_WR, k % 8, (k + al < trcd) ? 2 : 0, "R4");
        end

    // R5: active time sweep
    for (int tras = 1; tras <= 8; tras++)
      for (int k = 1; k <= 10; k++) begin
        restart(1, tras, 1, 1, 0);
        issue(K_ACT, tras % 8, 0, "R5");
        idle(k - 1, "R5");
        issue(K_PRE, tras % 8, (k < tras) ? 3 : 0, "R5");
      end
    // R5: precharge to a closed bank leaves its timer alone
    restart(1, 1, 6, 1, 0);
    issue(K_PRE, 3, 0, "R5");
    issue(K_ACT, 3, 0, "R5");

    // R6: reopen
    for (int k = 1; k <= 3; k++) begin
      restart(1, 1, 1, 1, 0);
      issue(K_ACT, 5, 0, "R6");
      idle(k - 1, "R6");
      issue(K_ACT, 5, 4, "R6");
      issue(K_DES, 0, 0, "R11");
    end

    // R7: precharge time sweep
    for (int trp = 1; trp <= 6; trp++)
      for (int k = 1; k <= 7; k++) begin
        restart(1, 1, trp, 1, 0);
        issue(K_ACT, 1, 0, "R7");
        issue(K_PRE, 1, 0, "R7");
        idle(k - 1, "R7");
        issue(K_ACT, 1, (k < trp) ? 5 : 0, "R7");
      end

    // R8: same-bank cycle time, precharge time met
    for (int tras = 1; tras <= 6; tras++)
      for (int trp = 1; trp <= 3; trp++)
        for (int k = trp; k <= trp + 5; k++) begin
          restart(1, tras, trp, 1, 0);
          issue(K_ACT, 6, 0, "R8");
          issue(K_PRE, 6, (1 < tras) ? 3 : 0, "R5 R8");
          idle(k - 1, "R8");
          issue(K_ACT, 6, (1 + k < tras + trp) ? 6 : 0, "R8");
        end

    // R9 / R11: cross-bank spacing, state still updated
    for (int trrd = 1; trrd <= 6; trrd++)
      for (int k = 1; k <= 7; k++) begin
        restart(2, 1, 1, trrd, 0);
        issue(K_ACT, 0, 0, "R9");
        idle(k - 1, "R9");
        issue(K_ACT, 1, (k < trrd) ? 7 : 0, "R9");
        issue(K_DES, 0, 0, "R11");
        issue(K_RD, 1, 0, "R11");
      end

    // R10: priority among activate rules
    restart(1, 1, 4, 4, 0);
    issue(K_ACT, 0, 0, "R10");
    issue(K_PRE, 0, 0, "R10");
    issue(K_ACT, 1, 7, "R10");
    issue(K_ACT, 0, 5, "R10");
    issue(K_ACT, 0, 4, "R10");

    // R12: out-of-range additive latency
    for (int al = 5; al <= 7; al++) begin
      restart(3, 1, 1, 1, al);
      check_flag(1'b1, "R12");
      issue(K_ACT, 2, 0, "R12");
      issue(K_RD, 2, 2, "R12");
    end
    restart(3, 1, 1, 1, 4);
    check_flag(1'b0, "R12");
    issue(K_ACT, 2, 0, "R12");
    issue(K_RD, 2, 0, "R12");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule